// File: doc/BRIEF.md
# Keyboard Port Register Interface

This block is the processor-facing front end of a PS/2-style serial port. A 32-bit bus slave exposes two word registers. The Data word sits at word offset 0 and the Control word at word offset 1. Bytes that an external bit-level receiver has already assembled arrive as a valid strobe with a byte. They are queued in a 256-entry receive FIFO.

A single processor read of the Data word returns three things: the oldest queued byte, a flag that says the byte is real, and the live occupancy. The same read removes that byte from the queue. A processor write of the Data word hands a command byte to an external bit-level transmitter as a one-cycle pulse.

The Control word holds three bits:
- a receive interrupt enable;
- a read-only pending bit that mirrors the interrupt line;
- a sticky flag that the transmitter raises when sending a command fails.

The interrupt is level-sensitive. Software clears it by draining the queue.

Top module: `kbd_port_regs`

## Requirements
- R1: After reset the queue is empty, the interrupt enable, the pending bit and the error flag are 0, `irq` and `cmd_valid` are 0, and both registers read as all zeros.
- R2: While the queue is not empty, a read of the Data word (bus_addr 0) returns bit 15 = 1, the oldest byte in bits 7:0 (bytes leave in arrival order), the occupancy including the returned byte in bits 31:16, and 0 in bits 14:8.
- R3: A read of the Data word with a non-empty queue removes exactly one entry, so the next read reports a count one lower.
- R4: A read of the Data word with an empty queue returns an all-zero word (bit 15 = 0, count 0) and removes nothing.
- R5: The queue holds 256 bytes. A byte that arrives while it is full is dropped, and the 256 stored bytes stay unchanged and in order.
- R6: A byte arrival and a Data read in the same cycle leave the count unchanged.
- R7: A write of the Data word raises `cmd_valid` for exactly the following cycle, with `cmd_byte` equal to write data bits 7:0. It leaves the queue untouched, and `cmd_valid` is 0 at all other times.
- R8: Control bit 0 is the interrupt enable and can be read back. `irq` is 1 exactly when the enable is 1 and the queue is not empty. Control bit 8 reads the same value as `irq`.
- R9: With the enable held at 1, `irq` stays 1 across reads until the last queued byte is read, and it is 0 from the cycle after that read.
- R10: A `cmd_error` pulse sets Control bit 10, which then holds. A Control write with bit 10 = 0 clears it, and a write with bit 10 = 1 leaves it set. If a pulse and a clearing write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe, one transfer per cycle |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_addr | input | 1 | Word offset: 0 is Data, 1 is Control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| rx_valid | input | 1 | Received byte strobe from the bit-level receiver |
| rx_byte | input | 8 | Received byte |
| cmd_valid | output | 1 | One-cycle command strobe toward the transmitter |
| cmd_byte | output | 8 | Command byte |
| cmd_error | input | 1 | Transmitter reports a failed command |
| irq | output | 1 | Receive interrupt, level |

## Verification
The bench fills the queue past its capacity and then drains it completely. A design whose pointers wrap wrongly or that accepts a 257th byte would return the wrong sequence or a count above 256. It reads an empty queue twice, which catches an underflowing count that would wrap to a large value, and it overlaps an arrival with a read, where a design that handles only one side would drift the count by one. It also exercises the interrupt at the exact read that empties the queue and a simultaneous error set with a clearing write. A design with a flag that clears too early, or where the clear wins, would show a wrong pending bit or a lost error.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;
  localparam int WORD_W      = 32;
  localparam int CNT_FIELD_W = 16;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_PEND_BIT = 8;
  localparam int CTRL_ERR_BIT  = 10;
  localparam int DATA_VLD_BIT  = 15;

  // Data word: occupancy on top, valid flag, byte at the bottom; all zero when empty.
  function automatic logic [WORD_W-1:0] pack_data(input logic [CNT_FIELD_W-1:0] cnt,
                                                  input logic [7:0] head_byte);
    logic [WORD_W-1:0] w;
    w = '0;
    if (cnt != '0) begin
      w[WORD_W-1:CNT_FIELD_W] = cnt;
      w[DATA_VLD_BIT]         = 1'b1;
      w[7:0]                  = head_byte;
    end
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_ctrl(input logic en, input logic pend,
                                                  input logic err);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CTRL_EN_BIT]   = en;
    w[CTRL_PEND_BIT] = pend;
    w[CTRL_ERR_BIT]  = err;
    return w;
  endfunction
endpackage

// File: rtl/kbd_rx_fifo.sv
module kbd_rx_fifo #(
  parameter  int DEPTH = 256,
  parameter  int DW    = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          push_fire,
  output logic          pop_fire
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign push_fire = push_req && !full;
  assign pop_fire  = pop_req && !empty;
  assign head      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_fire) wr_ptr <= ptr_next(wr_ptr);
      if (pop_fire)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_fire, pop_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R5
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop_req) |=> $stable(count)); // R5
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && !push_fire) |=> (count == $past(count) - 1'b1)); // R3
  AST_BOTH_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && push_fire) |=> $stable(count)); // R6
endmodule

// File: rtl/kbd_ctrl_regs.sv
module kbd_ctrl_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       data_wr,
  input  logic       ctrl_wr,
  input  logic [7:0] wr_byte,
  input  logic       wr_en_bit,
  input  logic       wr_err_bit,
  input  logic       cmd_error,
  output logic       irq_en,
  output logic       err_flag,
  output logic       cmd_valid,
  output logic [7:0] cmd_byte
);
  logic err_clear;
  assign err_clear = ctrl_wr && !wr_err_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en    <= 1'b0;
      err_flag  <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_byte  <= '0;
    end else begin
      if (ctrl_wr) irq_en <= wr_en_bit;
      err_flag  <= cmd_error || (err_flag && !err_clear);
      cmd_valid <= data_wr;
      if (data_wr) cmd_byte <= wr_byte;
    end
  end

  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (cmd_valid && cmd_byte == $past(wr_byte))); // R7
  AST_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> !cmd_valid); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clear) |=> err_flag); // R10
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_error |=> err_flag); // R10
endmodule

// File: rtl/kbd_port_regs.sv
module kbd_port_regs
  import kbd_port_pkg::*;
#(
  parameter  int DEPTH = 256,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic        bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic        cmd_valid,
  output logic [7:0]  cmd_byte,
  input  logic        cmd_error,
  output logic        irq
);
  logic          data_rd, data_wr, ctrl_wr;
  logic [7:0]    head;
  logic [CW-1:0] count;
  logic          push_fire, pop_fire;
  logic          irq_en, err_flag;
  logic          unused_wbits;

  assign data_rd = bus_rd && !bus_addr;
  assign data_wr = bus_wr && !bus_addr;
  assign ctrl_wr = bus_wr && bus_addr;
  assign unused_wbits = ^{bus_wdata[31:11], bus_wdata[9:8]};

  kbd_rx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_req(rx_valid), .push_data(rx_byte),
    .pop_req(data_rd), .head(head), .count(count),
    .push_fire(push_fire), .pop_fire(pop_fire)
  );

  kbd_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .data_wr(data_wr), .ctrl_wr(ctrl_wr),
    .wr_byte(bus_wdata[7:0]),
    .wr_en_bit(bus_wdata[CTRL_EN_BIT]),
    .wr_err_bit(bus_wdata[CTRL_ERR_BIT]),
    .cmd_error(cmd_error),
    .irq_en(irq_en), .err_flag(err_flag),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte)
  );

  assign irq = irq_en && (count != '0);

  always_comb begin
    if (bus_addr) bus_rdata = pack_ctrl(irq_en, irq, err_flag);
    else          bus_rdata = pack_data(CNT_FIELD_W'(count), head);
  end

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !pop_fire && !ctrl_wr) |=> irq); // R9
  AST_IRQ_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && pop_fire && !push_fire && count == CW'(1)) |=> !irq); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !bus_wdata[CTRL_EN_BIT]) |=> !irq); // R8
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && count == '0) |-> bus_rdata == '0); // R4
endmodule

// File: tb/kbd_port_regs_bench.sv
module kbd_port_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        cmd_valid;
  logic [7:0]  cmd_byte;
  logic        cmd_error = 1'b0;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  kbd_port_regs u_kbd_port_regs (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .cmd_valid(cmd_valid),
    .cmd_byte(cmd_byte), .cmd_error(cmd_error), .irq(irq)
  );

  function automatic logic [31:0] exp_data(int cnt, int b);
    return (cnt == 0) ? 32'd0 : ((cnt << 16) | 32'h8000 | (b & 255));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic a, output logic [31:0] w);
    bus_addr = a; bus_rd = 1'b1; #1; w = bus_rdata;
    tick(); bus_rd = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    tick(); bus_wr = 1'b0;
  endtask

  task automatic push(input int b);
    rx_valid = 1'b1; rx_byte = 8'(b);
    tick(); rx_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] w;
    tick(); tick(); rst_n = 1'b1; tick();
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 cmd_valid", 32'(cmd_valid), 0);
    rd(1'b1, w); chk("R1 ctrl", w, 0);
    rd(1'b0, w); chk("R1 data", w, 0);
    // R4 empty reads do not underflow
    rd(1'b0, w); chk("R4 empty again", w, 0);
    // R2/R3 small pattern
    for (int i = 0; i < 5; i++) push((i * 37 + 11) & 255);
    for (int i = 0; i < 5; i++) begin
      rd(1'b0, w); chk("R2 R3 ordered read", w, exp_data(5 - i, (i * 37 + 11) & 255));
    end
    rd(1'b0, w); chk("R4 drained", w, 0);
    push(8'h3c);
    rd(1'b0, w); chk("R4 no underflow", w, exp_data(1, 8'h3c));
    // R5 fill past capacity, drain all
    for (int i = 0; i < 300; i++) push(i);
    for (int i = 0; i < 256; i++) begin
      rd(1'b0, w); chk("R5 full drain", w, exp_data(256 - i, i));
    end
    rd(1'b0, w); chk("R5 extra dropped", w, 0);
    // R6 simultaneous arrival and read
    for (int i = 0; i < 3; i++) push(8'h50 + i);
    rx_valid = 1'b1; rx_byte = 8'h77; bus_addr = 1'b0; bus_rd = 1'b1; #1;
    chk("R6 overlap read", bus_rdata, exp_data(3, 8'h50));
    tick(); rx_valid = 1'b0; bus_rd = 1'b0;
    rd(1'b0, w); chk("R6 count steady", w, exp_data(3, 8'h51));
    rd(1'b0, w); chk("R6 next", w, exp_data(2, 8'h52));
    rd(1'b0, w); chk("R6 arrived byte", w, exp_data(1, 8'h77));
    // R7 command write
    chk("R7 idle", 32'(cmd_valid), 0);
    wr(1'b0, 32'h0000_01a5);
    chk("R7 pulse", 32'(cmd_valid), 1);
    chk("R7 byte", 32'(cmd_byte), 32'ha5);
    tick();
    chk("R7 one cycle", 32'(cmd_valid), 0);
    rd(1'b0, w); chk("R7 queue untouched", w, 0);
    // R8/R9 interrupt
    wr(1'b1, 32'h1);
    chk("R8 empty no irq", 32'(irq), 0);
    rd(1'b1, w); chk("R8 ctrl en", w, 32'h1);
    push(8'h11); push(8'h22);
    chk("R8 irq set", 32'(irq), 1);
    rd(1'b1, w); chk("R8 pending bit", w, 32'h101);
    rd(1'b0, w); chk("R9 hold after read", 32'(irq), 1);
    rd(1'b0, w); chk("R9 last byte", w, exp_data(1, 8'h22));
    chk("R9 cleared", 32'(irq), 0);
    push(8'h33);
    chk("R8 irq again", 32'(irq), 1);
    wr(1'b1, 32'h0);
    chk("R8 disabled", 32'(irq), 0);
    rd(1'b1, w); chk("R8 ctrl disabled", w, 0);
    rd(1'b0, w); chk("R8 byte kept", w, exp_data(1, 8'h33));
    // R10 error flag
    cmd_error = 1'b1; tick(); cmd_error = 1'b0;
    rd(1'b1, w); chk("R10 set", w, 32'h400);
    tick(); tick();
    rd(1'b1, w); chk("R10 sticky", w, 32'h400);
    wr(1'b1, 32'h400);
    rd(1'b1, w); chk("R10 write one keeps", w, 32'h400);
    wr(1'b1, 32'h0);
    rd(1'b1, w); chk("R10 cleared", w, 0);
    cmd_error = 1'b1; bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = 0;
    tick(); cmd_error = 1'b0; bus_wr = 1'b0;
    rd(1'b1, w); chk("R10 set wins", w, 32'h400);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule